// File: doc/BRIEF.md
# Real-Time Clock with Alarm

This block keeps a seconds count and raises an interrupt when that count moves past a programmed alarm. Software reaches it through a plain register port with an address, a write strobe, write data and combinational read data. The seconds tick comes from the `tick_in` input. When `TICKS_PER_SEC` is 1, each pulse on `tick_in` is one second. When it is larger, an internal prescaler divides the pulses down. `tick_in` is assumed to be synchronous to `clk` and one cycle wide.

Software writes to the time, alarm, mask and acknowledge registers, and those writes land in holding registers. None of them reaches the live timekeeping state straight away. A write is applied on the first seconds tick after it and stays visible as busy until the following tick. Each of the four kinds of write has its own busy bit in a status word, so software can poll for completion. The interrupt output is the latched alarm flag gated by the applied mask.

Top module: `rtc_seconds_alarm`

## Requirements
- R1: After reset the time, alarm, mask, latched alarm flag and all busy bits are zero, and `irq` is low.
- R2: Offset 0x00 reads the time, zero-extended. On every seconds tick the time rises by one, wrapping modulo 2^TW, unless a time load is applied on that tick. Between ticks it does not change.
- R3: A write to offset 0x08 is read back at once in full. Its low TW bits become the time on the first tick after the write. Status bit 0 reads 1 from the write until the second tick after it.
- R4: A write to offset 0x04 is read back at once in full. Its low TW bits become the applied alarm on the first tick after the write. Status bit 1 is busy over the same two-tick window.
- R5: A write to offset 0x0C stores bit 0 as the mask value, and the mask reads back at once. The value is applied on the first tick after the write. Status bit 3 is busy over the two-tick window.
- R6: A write to offset 0x10 with bit 0 set requests an acknowledge. The request sets status bit 2, and on the first tick after the write it clears the latched alarm flag. A write to 0x10 with bit 0 clear changes nothing.
- R7: The latched alarm flag sets one cycle after the time first becomes strictly greater than the applied alarm. It then stays set until it is acknowledged, even if the time is later loaded back below the alarm.
- R8: `irq` and bit 0 of offset 0x10 are both 1 exactly when the latched flag and the applied mask are both 1. All other bits of 0x10 read 0.
- R9: Offset 0x14 reads the busy bits in these positions: bit 0 time load, bit 1 alarm, bit 2 acknowledge, bit 3 mask. All higher bits read 0. Unused offsets read 0. Writes to 0x00, 0x14 and unused offsets have no effect.
- R10: A new write of a kind that is already busy replaces the held value and restarts that kind's two-tick window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register-port clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_in | input | 1 | One-cycle timebase pulse, divided by TICKS_PER_SEC |
| wr_en | input | 1 | Write strobe |
| addr | input | ADDR_W | Byte offset of the register |
| wr_data | input | DW | Write data |
| rd_data | output | DW | Read data for `addr`, combinational |
| irq | output | 1 | Masked alarm interrupt |

## Verification
The bench builds the block with `TICKS_PER_SEC` = 1, so each pulse it drives on `tick_in` counts as one second. This makes the tick that applies a write and the tick that clears its busy bit land on cycles the bench chooses. It also sets `TW` = 16, which puts the counter wrap within a few ticks of a load of 0xFFFE. Random alarm values are kept close to the current time, so alarms fire, get acknowledged and are re-armed many times during the run.

// File: rtl/rtc_pkg.sv
// Package: shared offsets, operation indices and slot states for the seconds
// counter with alarm. Operation indices are also status-word bit positions.
package rtc_pkg;

    localparam int unsigned OFS_TIME   = 32'h00;
    localparam int unsigned OFS_ALARM  = 32'h04;
    localparam int unsigned OFS_LOAD   = 32'h08;
    localparam int unsigned OFS_MASK   = 32'h0C;
    localparam int unsigned OFS_INT    = 32'h10;
    localparam int unsigned OFS_STATUS = 32'h14;

    localparam int unsigned NUM_OPS = 4;
    localparam int unsigned OP_LOAD  = 0;
    localparam int unsigned OP_ALARM = 1;
    localparam int unsigned OP_ACK   = 2;
    localparam int unsigned OP_MASK  = 3;

    typedef enum logic [1:0] {
        SLOT_IDLE = 2'd0,
        SLOT_TAIL = 2'd1,
        SLOT_WAIT = 2'd2
    } slot_e;

endpackage

// File: rtl/rtc_xfer_slot.sv
// Module: tracks one kind of deferred write on its way into the seconds domain.
// A request arms the slot. The first seconds tick after that pulses `apply`,
// and the next tick returns the slot to idle. `busy` covers the whole window.
// Assumes req and sec_tick are synchronous one-cycle strobes.
module rtc_xfer_slot
    import rtc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic sec_tick,
    output logic apply,
    output logic busy
);

    slot_e state_q;

    // Purpose: step the slot on a request or a seconds tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SLOT_IDLE;
        end else if (req) begin
            state_q <= SLOT_WAIT;
        end else if (sec_tick) begin
            case (state_q)
                SLOT_WAIT: state_q <= SLOT_TAIL;
                default:   state_q <= SLOT_IDLE;
            endcase
        end
    end

    assign apply = sec_tick && (state_q == SLOT_WAIT);
    assign busy  = (state_q != SLOT_IDLE);

endmodule

// File: rtl/rtc_alarm_flag.sv
// Module: sticky alarm flag. It sets on the cycle after the time first exceeds
// the alarm, and clears on an applied acknowledge. If both happen in one
// cycle, the set wins. Assumes time and alarm change only on seconds ticks.
module rtc_alarm_flag #(
    parameter int TW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] time_q,
    input  logic [TW-1:0] alarm_q,
    input  logic          clr,
    output logic          raw_flag
);

    logic past_now;
    logic past_d;

    assign past_now = (time_q > alarm_q);

    // Purpose: remember the last compare result for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) past_d <= 1'b0;
        else        past_d <= past_now;
    end

    // Purpose: latch the alarm event until it is acknowledged.
    always_ff @(posedge clk) begin
        if (!rst_n)                  raw_flag <= 1'b0;
        else if (past_now && !past_d) raw_flag <= 1'b1;
        else if (clr)                raw_flag <= 1'b0;
    end

endmodule

// File: rtl/rtc_seconds_alarm.sv
// Module: top of the seconds counter with alarm. It holds the written values,
// the applied timekeeping state and the read mux. Every write is deferred
// through its own transfer slot. Assumes tick_in is synchronous to clk and one
// cycle wide, and that TW <= DW.
module rtc_seconds_alarm
    import rtc_pkg::*;
#(
    parameter int TW            = 32,
    parameter int DW            = 32,
    parameter int ADDR_W        = 5,
    parameter int TICKS_PER_SEC = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_in,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wr_data,
    output logic [DW-1:0]     rd_data,
    output logic              irq
);

    logic                sec_tick;
    logic [NUM_OPS-1:0]  op_req;
    logic [NUM_OPS-1:0]  op_apply;
    logic [NUM_OPS-1:0]  op_busy;
    logic [DW-1:0]       load_hold;
    logic [DW-1:0]       alarm_hold;
    logic                mask_hold;
    logic [TW-1:0]       time_q;
    logic [TW-1:0]       alarm_q;
    logic                mask_q;
    logic                raw_flag;
    logic                ack_apply;
    logic                load_apply;

    // Seconds tick: pass the input through, or divide it when asked to.
    generate
        if (TICKS_PER_SEC > 1) begin : g_presc
            localparam int PW = $clog2(TICKS_PER_SEC);
            localparam logic [PW-1:0] LAST = PW'(TICKS_PER_SEC - 1);
            logic [PW-1:0] pcnt_q;
            // Purpose: count timebase pulses up to one second.
            always_ff @(posedge clk) begin
                if (!rst_n)       pcnt_q <= '0;
                else if (tick_in) pcnt_q <= (pcnt_q == LAST) ? '0 : pcnt_q + 1'b1;
            end
            assign sec_tick = tick_in && (pcnt_q == LAST);
        end else begin : g_direct
            assign sec_tick = tick_in;
        end
    endgenerate

    // Write decode into per-operation requests.
    always_comb begin
        op_req           = '0;
        op_req[OP_LOAD]  = wr_en && (addr == ADDR_W'(OFS_LOAD));
        op_req[OP_ALARM] = wr_en && (addr == ADDR_W'(OFS_ALARM));
        op_req[OP_MASK]  = wr_en && (addr == ADDR_W'(OFS_MASK));
        op_req[OP_ACK]   = wr_en && (addr == ADDR_W'(OFS_INT)) && wr_data[0];
    end

    generate
        for (genvar i = 0; i < NUM_OPS; i++) begin : g_slot
            rtc_xfer_slot u_slot (
                .clk      (clk),
                .rst_n    (rst_n),
                .req      (op_req[i]),
                .sec_tick (sec_tick),
                .apply    (op_apply[i]),
                .busy     (op_busy[i])
            );
        end
    endgenerate

    assign ack_apply  = op_apply[OP_ACK];
    assign load_apply = op_apply[OP_LOAD];

    // Purpose: capture written values on the register side.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_hold  <= '0;
            alarm_hold <= '0;
            mask_hold  <= 1'b0;
        end else begin
            if (op_req[OP_LOAD])  load_hold  <= wr_data;
            if (op_req[OP_ALARM]) alarm_hold <= wr_data;
            if (op_req[OP_MASK])  mask_hold  <= wr_data[0];
        end
    end

    // Purpose: advance or load the seconds count on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n)          time_q <= '0;
        else if (load_apply) time_q <= load_hold[TW-1:0];
        else if (sec_tick)   time_q <= time_q + 1'b1;
    end

    // Purpose: move held alarm and mask into the applied state on a tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alarm_q <= '0;
            mask_q  <= 1'b0;
        end else begin
            if (op_apply[OP_ALARM]) alarm_q <= alarm_hold[TW-1:0];
            if (op_apply[OP_MASK])  mask_q  <= mask_hold;
        end
    end

    rtc_alarm_flag #(.TW(TW)) u_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .time_q   (time_q),
        .alarm_q  (alarm_q),
        .clr      (ack_apply),
        .raw_flag (raw_flag)
    );

    assign irq = raw_flag && mask_q;

    // Purpose: combinational read mux; unused offsets read zero.
    always_comb begin
        case (addr)
            ADDR_W'(OFS_TIME):   rd_data = DW'(time_q);
            ADDR_W'(OFS_ALARM):  rd_data = alarm_hold;
            ADDR_W'(OFS_LOAD):   rd_data = load_hold;
            ADDR_W'(OFS_MASK):   rd_data = DW'(mask_hold);
            ADDR_W'(OFS_INT):    rd_data = DW'(irq);
            ADDR_W'(OFS_STATUS): rd_data = DW'(op_busy);
            default:             rd_data = '0;
        endcase
    end

endmodule

// File: rtl/rtc_seconds_alarm_chk.sv
// Module: assertion checker bound to the seconds counter top. It observes the
// tick, the writes, the applied state and the alarm flag. It drives nothing.
module rtc_seconds_alarm_chk
    import rtc_pkg::*;
#(
    parameter int TW     = 32,
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sec_tick,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [TW-1:0]     time_q,
    input logic [TW-1:0]     alarm_q,
    input logic              raw_flag,
    input logic              ack_apply,
    input logic              load_apply,
    input logic [3:0]        op_busy
);

    // R2: no tick, no change of the count.
    p_time_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !sec_tick |=> $stable(time_q));

    // R2: a tick without a load steps the count by one.
    p_time_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && !load_apply) |=> (time_q == TW'($past(time_q) + 1'b1)));

    // R3: the load busy bit only rises after a load write.
    p_load_busy_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(op_busy[0]) |-> $past(wr_en && (addr == ADDR_W'(OFS_LOAD))));

    // R4: the alarm busy bit only rises after an alarm write.
    p_alarm_busy_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(op_busy[1]) |-> $past(wr_en && (addr == ADDR_W'(OFS_ALARM))));

    // R9: busy bits only drop on a seconds tick.
    p_busy_fall_on_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones($past(op_busy) & ~op_busy) != 0) |-> $past(sec_tick));

    // R7: the flag rises only once the time has passed the alarm.
    p_flag_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(raw_flag) |-> $past(time_q > alarm_q));

    // R6: the flag falls only through an applied acknowledge.
    p_flag_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(raw_flag) |-> $past(ack_apply));

endmodule

bind rtc_seconds_alarm rtc_seconds_alarm_chk #(.TW(TW), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sec_tick   (sec_tick),
    .wr_en      (wr_en),
    .addr       (addr),
    .time_q     (time_q),
    .alarm_q    (alarm_q),
    .raw_flag   (raw_flag),
    .ack_apply  (ack_apply),
    .load_apply (load_apply),
    .op_busy    (op_busy)
);

// File: tb/sim_rtc_seconds_alarm.sv
// Bench: directed corners plus seeded random writes, ticks and reads, checked
// against a behavioural model built from the requirements.
module sim_rtc_seconds_alarm;

    localparam int TW = 16;
    localparam int DW = 32;
    localparam int AW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick_in = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic          irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // model state
    logic [TW-1:0] m_time = '0;
    logic [TW-1:0] m_alarm = '0;
    logic [DW-1:0] m_load_h = '0;
    logic [DW-1:0] m_alarm_h = '0;
    logic          m_mask_h = 1'b0;
    logic          m_mask = 1'b0;
    logic          m_raw = 1'b0;
    logic          m_past = 1'b0;
    int            m_cnt [4] = '{0, 0, 0, 0};

    always #4 clk = ~clk;

    rtc_seconds_alarm #(.TW(TW), .DW(DW), .ADDR_W(AW), .TICKS_PER_SEC(1)) u0 (
        .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .wr_en(wr_en),
        .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
    );

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_status();
        logic [3:0] s;
        for (int i = 0; i < 4; i++) s[i] = (m_cnt[i] != 0);
        return s;
    endfunction

    function automatic logic [DW-1:0] exp_read(input logic [AW-1:0] a);
        case (a)
            5'h00:   return DW'(m_time);
            5'h04:   return m_alarm_h;
            5'h08:   return m_load_h;
            5'h0C:   return DW'(m_mask_h);
            5'h10:   return DW'(m_raw & m_mask);
            5'h14:   return DW'(exp_status());
            default: return '0;
        endcase
    endfunction

    task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] v);
        addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        case (a)
            5'h08: begin m_load_h = d; m_cnt[0] = 2; end
            5'h04: begin m_alarm_h = d; m_cnt[1] = 2; end
            5'h0C: begin m_mask_h = d[0]; m_cnt[3] = 2; end
            5'h10: if (d[0]) m_cnt[2] = 2;
            default: ;
        endcase
    endtask

    task automatic model_tick();
        logic ld;
        ld = (m_cnt[0] == 2);
        if (m_cnt[1] == 2) m_alarm = m_alarm_h[TW-1:0];
        if (m_cnt[3] == 2) m_mask = m_mask_h;
        if (m_cnt[2] == 2) m_raw = 1'b0;
        m_time = ld ? m_load_h[TW-1:0] : m_time + 1'b1;
        for (int i = 0; i < 4; i++) if (m_cnt[i] > 0) m_cnt[i]--;
        if ((m_time > m_alarm) && !m_past) m_raw = 1'b1;
        m_past = (m_time > m_alarm);
    endtask

    task automatic check_all();
        logic [DW-1:0] v;
        rd(5'h00, v); chk("R2 time", v, exp_read(5'h00));
        rd(5'h04, v); chk("R4 alarm readback", v, exp_read(5'h04));
        rd(5'h08, v); chk("R3 load readback", v, exp_read(5'h08));
        rd(5'h0C, v); chk("R5 mask readback", v, exp_read(5'h0C));
        rd(5'h10, v); chk("R8 int reg", v, exp_read(5'h10));
        rd(5'h14, v); chk("R9 status", v, exp_read(5'h14));
        chk("R8 irq pin", DW'(irq), DW'(m_raw & m_mask));
    endtask

    task automatic tick();
        @(negedge clk);
        tick_in = 1'b1;
        @(negedge clk);
        tick_in = 1'b0;
        model_tick();
        @(negedge clk);
        check_all();
    endtask

    initial begin
        logic [DW-1:0] v;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        for (int a = 0; a < 8; a++) begin
            rd(AW'(a * 4), v);
            chk("R1 reset read", v, '0);
        end
        chk("R1 reset irq", DW'(irq), '0);

        // R3 load then wrap (R2)
        wr(5'h08, 32'hABCD_FFFE);
        rd(5'h14, v); chk("R3 load busy", v, 32'h1);
        rd(5'h00, v); chk("R3 time not yet loaded", v, '0);
        tick();
        rd(5'h00, v); chk("R3 loaded on first tick", v, 32'hFFFE);
        rd(5'h14, v); chk("R3 busy until second tick", v, 32'h1);
        tick();
        rd(5'h14, v); chk("R3 busy cleared", v, '0);
        tick();
        rd(5'h00, v); chk("R2 wrap", v, '0);

        // R9 ignored writes and unused offsets
        wr(5'h00, 32'h1234);
        wr(5'h14, 32'hF);
        wr(5'h18, 32'h55);
        rd(5'h00, v); chk("R9 time write ignored", v, '0);
        rd(5'h14, v); chk("R9 status write ignored", v, '0);
        rd(5'h18, v); chk("R9 unused offset", v, '0);

        // R6 ack with bit0 clear has no effect
        wr(5'h10, 32'hFFFF_FFFE);
        rd(5'h14, v); chk("R6 zero ack ignored", v, '0);
        check_all();

        // R7 / R8 / R6 alarm sequence
        wr(5'h10, 32'h1);
        wr(5'h04, 32'h0000_0003);
        wr(5'h0C, 32'h1);
        rd(5'h14, v); chk("R9 three busy bits", v, 32'hE);
        tick(); tick();
        chk("R6 flag cleared", DW'(irq), '0);
        tick(); tick();
        chk("R7 alarm fired", DW'(irq), 32'h1);
        wr(5'h08, 32'h0);
        tick(); tick();
        chk("R7 flag sticky after reload", DW'(irq), 32'h1);
        wr(5'h0C, 32'h0);
        tick();
        chk("R8 masked off", DW'(irq), '0);
        wr(5'h0C, 32'h1);
        wr(5'h10, 32'h1);
        tick();
        chk("R6 ack cleared", DW'(irq), '0);
        tick();

        // R10 rewrite restarts window
        wr(5'h08, 32'h100);
        tick();
        wr(5'h08, 32'h200);
        tick();
        rd(5'h00, v); chk("R10 second value applied", v, 32'h200);
        rd(5'h14, v); chk("R10 window restarted", v, 32'h1);
        tick();

        // random phase
        for (int n = 0; n < 400; n++) begin
            int sel;
            sel = $urandom % 8;
            case (sel)
                0: wr(5'h08, $urandom);
                1: wr(5'h04, DW'(m_time) + ($urandom % 4));
                2: wr(5'h0C, $urandom);
                3: wr(5'h10, $urandom);
                4: begin
                    logic [AW-1:0] a;
                    a = AW'(($urandom % 8) * 4);
                    @(negedge clk);
                    rd(a, v);
                    chk("R9 random read", v, exp_read(a));
                end
                default: tick();
            endcase
        end
        check_all();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL R1 watchdog expired actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule